// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog that counts ticks of a slow, free-running clock (nominally 250 kHz, independent of the system clock). It issues a reset pulse when its counter reaches the overflow threshold picked by a 3-bit period code. The slow tick enters the system clock domain through a two-flop synchronizer followed by a rising-edge detector. The counter advances once for each detected edge, and only while the enable bit is set.

Software reaches the block through a simple register port with a write strobe, a write address and byte, and a read address with combinational read data. The registers are:
- Control: enable in bit 7, counter clear in bit 5, period code in bits 2:0.
- Key: address 1.
- Status: the reset-cause flag in bit 7.

After any reset the control register ignores writes. A small key state machine opens it when the bytes 0x1E and then 0xE1 are written to the key register. It closes it again when 0xE1 and then 0x1E are written. The four states and their transitions are:
- LOCKED goes to ARMING on 0x1E. Any other key byte keeps it in LOCKED.
- ARMING goes to OPEN on 0xE1. Any other key byte returns it to LOCKED.
- OPEN goes to CLOSING on 0xE1. Any other key byte keeps it in OPEN.
- CLOSING goes to LOCKED on 0x1E. Any other key byte returns it to OPEN.
- The control register is writable in OPEN and CLOSING.
- A hardware reset or a watchdog overflow forces the machine to LOCKED.

The reset-cause flag survives the reset it reports. Only power-on reset or a software write clears it.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset (`rst_n` low), the control, key and status registers read 0x00, `wdt_rst_o` is low, and the key state is LOCKED.
- R2: In LOCKED or ARMING, a write to the control register (address 0) has no effect on its read-back value.
- R3: Writing 0x1E and then 0xE1 to the key register (address 1) makes the control register writable, and a following control write is visible on reads from the next cycle. The key register reads back the last byte written to it.
- R4: While writable, writing 0xE1 and then 0x1E to the key register makes the control register read-only again.
- R5: A key byte that breaks a sequence returns the state machine to the side it started from: ARMING falls back to LOCKED, and CLOSING falls back to OPEN. Writes to other addresses do not disturb the sequence.
- R6: When enabled, the counter advances once per rising edge of `slow_tick`. An edge first sampled at clock k is counted at clock k+2. When disabled, the counter does not advance.
- R7: Period code p in control bits 2:0 sets an overflow after 2^(BASE_SHIFT+p) counted ticks, so the period doubles with each code step.
- R8: Writing control with bit 5 set, while writable, zeroes the counter and restarts the count. Bit 5 always reads as 0.
- R9: On the clock that counts the overflowing tick, `wdt_rst_o` rises. It stays high for exactly PULSE_CYC cycles unless `hw_rst_n` cuts it short.
- R10: An overflow clears the enable bit and the period code, zeroes the counter, returns the key state to LOCKED with the key register at 0x00, and sets status bit 7.
- R11: Status bit 7 takes bit 7 of a software write to address 2. It keeps its value through `hw_rst_n` and is cleared only by `rst_n` or by software.
- R12: A synchronous `hw_rst_n` low clears the enable bit, the period code, the counter, the key state and key byte, and any reset pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| hw_rst_n | input | 1 | Synchronous hardware reset, active low; keeps the status flag |
| slow_tick | input | 1 | Asynchronous slow oscillator clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 key, 2 status |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 2 | Read address (3 reads 0x00) |
| rd_data | output | 8 | Combinational read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The effects of register writes and key bytes appear on `rd_data` in the cycle after the clock edge that takes them. A rising edge of `slow_tick` reaches the counter two clock edges after it is first sampled. When that tick causes the overflow, `wdt_rst_o` rises on the same edge as the counter update and falls PULSE_CYC edges later. The bench carries a behavioural model that is stepped on every rising edge from the inputs sampled at that edge. Inputs change only on falling edges, and outputs are compared 3 ns after each rising edge, so every expected value already includes the synchronizer and register delays.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED  = 2'd0,
        KS_ARMING  = 2'd1,
        KS_OPEN    = 2'd2,
        KS_CLOSING = 2'd3
    } key_state_e;

    localparam logic [7:0] KEY_A = 8'h1E;
    localparam logic [7:0] KEY_B = 8'hE1;

    localparam logic [1:0] ADR_CTL = 2'd0;
    localparam logic [1:0] ADR_KEY = 2'd1;
    localparam logic [1:0] ADR_STS = 2'd2;

    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_CLR_BIT  = 5;
    localparam int STS_FLAG_BIT = 7;

endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], tick_async};
    end

    assign tick_rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_keyed_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_lock,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       writable,
    output logic [7:0] key_q
);
    key_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (key_wr) begin
            unique case (state)
                KS_LOCKED:  state_nx = (key_byte == KEY_A) ? KS_ARMING : KS_LOCKED;
                KS_ARMING:  state_nx = (key_byte == KEY_B) ? KS_OPEN   : KS_LOCKED;
                KS_OPEN:    state_nx = (key_byte == KEY_B) ? KS_CLOSING : KS_OPEN;
                KS_CLOSING: state_nx = (key_byte == KEY_A) ? KS_LOCKED : KS_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= KS_LOCKED;
            key_q <= '0;
        end else if (force_lock) begin
            state <= KS_LOCKED;
            key_q <= '0;
        end else begin
            state <= state_nx;
            if (key_wr) key_q <= key_byte;
        end
    end

    always_comb begin
        writable = (state == KS_OPEN) || (state == KS_CLOSING);
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W      = 16,
    parameter int BASE_SHIFT = 9,
    parameter int PULSE_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_rst_n,
    input  logic             tick_rise,
    input  logic             ctl_wr,
    input  logic             writable,
    input  logic             d_en,
    input  logic             d_clr,
    input  logic [2:0]       d_ps,
    input  logic             sts_wr,
    input  logic             d_flag,
    output logic             en_q,
    output logic [2:0]       ps_q,
    output logic             flag_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf,
    output logic             wdt_rst
);
    localparam int LIM_W = CNT_W + 1;
    localparam int PW    = $clog2(PULSE_CYC + 1);

    generate
        if (CNT_W < BASE_SHIFT + 7) begin : g_bad_width
            $error("wdt_core: CNT_W too small for the longest period");
        end
    endgenerate

    logic [LIM_W-1:0] limit;
    logic [CNT_W-1:0] last_val;
    logic [PW-1:0]    pulse_q;
    logic             ctl_take;

    assign limit    = LIM_W'(1) << (BASE_SHIFT + int'(ps_q));
    assign last_val = CNT_W'(limit - LIM_W'(1));
    assign ovf      = hw_rst_n && en_q && tick_rise && (cnt_q == last_val);
    assign ctl_take = ctl_wr && writable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ps_q  <= '0;
            cnt_q <= '0;
        end else if (!hw_rst_n || ovf) begin
            en_q  <= 1'b0;
            ps_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (ctl_take) begin
                en_q <= d_en;
                ps_q <= d_ps;
            end
            if (ctl_take && d_clr)       cnt_q <= '0;
            else if (en_q && tick_rise)  cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (ovf)    flag_q <= 1'b1;
        else if (sts_wr) flag_q <= d_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pulse_q <= '0;
        else if (!hw_rst_n)      pulse_q <= '0;
        else if (ovf)            pulse_q <= PW'(PULSE_CYC);
        else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end

    assign wdt_rst = (pulse_q != '0);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BASE_SHIFT  = 9,
    parameter int PULSE_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst_n,
    input  logic       slow_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       wdt_rst_o
);
    logic             tick_rise;
    logic             ctl_wr, key_wr, sts_wr;
    logic             writable;
    logic [7:0]       key_q;
    logic             en_q, flag_q, ovf;
    logic [2:0]       ps_q;
    logic [CNT_W-1:0] cnt_q;

    assign ctl_wr = wr_en && (wr_addr == ADR_CTL);
    assign key_wr = wr_en && (wr_addr == ADR_KEY);
    assign sts_wr = wr_en && (wr_addr == ADR_STS);

    wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_async(slow_tick), .tick_rise(tick_rise)
    );

    wdt_key_fsm u_key (
        .clk(clk), .rst_n(rst_n), .force_lock(!hw_rst_n || ovf),
        .key_wr(key_wr), .key_byte(wr_data),
        .writable(writable), .key_q(key_q)
    );

    wdt_core #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT), .PULSE_CYC(PULSE_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .tick_rise(tick_rise),
        .ctl_wr(ctl_wr), .writable(writable),
        .d_en(wr_data[CTL_EN_BIT]), .d_clr(wr_data[CTL_CLR_BIT]), .d_ps(wr_data[2:0]),
        .sts_wr(sts_wr), .d_flag(wr_data[STS_FLAG_BIT]),
        .en_q(en_q), .ps_q(ps_q), .flag_q(flag_q), .cnt_q(cnt_q),
        .ovf(ovf), .wdt_rst(wdt_rst_o)
    );

    always_comb begin
        case (rd_addr)
            ADR_CTL: rd_data = {en_q, 4'b0000, ps_q};
            ADR_KEY: rd_data = key_q;
            ADR_STS: rd_data = {flag_q, 7'b0000000};
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int PULSE_CYC = 4,
    parameter int CNT_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_rst_n,
    input logic             ctl_wr,
    input logic             sts_wr,
    input logic             writable,
    input logic             ovf,
    input logic             en_q,
    input logic             flag_q,
    input logic             wdt_rst_o,
    input logic [2:0]       ps_q,
    input logic [CNT_W-1:0] cnt_q
);
    logic [7:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_len <= '0;
        else if (wdt_rst_o) hi_len <= hi_len + 1'b1;
        else                hi_len <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wdt_rst_o) && $past(hw_rst_n)) |-> (hi_len == 8'(PULSE_CYC))); // R9

    AST_OVF_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (wdt_rst_o && flag_q && !en_q && !writable)); // R10

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !writable && hw_rst_n && !ovf) |=> ($stable(en_q) && $stable(ps_q))); // R2

    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ($stable(cnt_q) || cnt_q == '0)); // R6

    AST_HW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> (!en_q && ps_q == 3'd0 && !writable && !wdt_rst_o)); // R12

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !sts_wr) |=> $stable(flag_q)); // R11
endmodule

bind wdt_keyed wdt_keyed_chk #(.PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .ctl_wr(ctl_wr), .sts_wr(sts_wr),
    .writable(writable), .ovf(ovf), .en_q(en_q), .flag_q(flag_q),
    .wdt_rst_o(wdt_rst_o), .ps_q(ps_q), .cnt_q(cnt_q)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
    localparam int CW = 9;
    localparam int BS = 2;
    localparam int PC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_rst_n = 1'b1;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       wdt_rst_o;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    tick_on = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    wdt_keyed #(.CNT_W(CW), .BASE_SHIFT(BS), .PULSE_CYC(PC)) uut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .slow_tick(slow_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst_o(wdt_rst_o)
    );

    // behavioural reference model
    int m_s1, m_s2, m_s3, m_cnt, m_en, m_ps, m_flag, m_pulse, m_ks, m_key;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_en = 0; m_ps = 0;
            m_flag = 0; m_pulse = 0; m_ks = 0; m_key = 0;
        end else begin
            bit rise, kw, cw, sw, wrt, ovf;
            rise = (m_s2 != 0) && (m_s3 == 0);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(slow_tick);
            kw  = wr_en && wr_addr == 2'd1;
            cw  = wr_en && wr_addr == 2'd0;
            sw  = wr_en && wr_addr == 2'd2;
            wrt = (m_ks >= 2);
            ovf = hw_rst_n && (m_en != 0) && rise && (m_cnt == (1 << (BS + m_ps)) - 1);
            if (ovf) m_flag = 1;
            else if (sw) m_flag = int'(wr_data[7]);
            if (!hw_rst_n) m_pulse = 0;
            else if (ovf) m_pulse = PC;
            else if (m_pulse > 0) m_pulse--;
            if (!hw_rst_n || ovf) begin
                m_ks = 0; m_key = 0;
            end else if (kw) begin
                m_key = int'(wr_data);
                case (m_ks)
                    0: m_ks = (wr_data == 8'h1E) ? 1 : 0;
                    1: m_ks = (wr_data == 8'hE1) ? 2 : 0;
                    2: m_ks = (wr_data == 8'hE1) ? 3 : 2;
                    default: m_ks = (wr_data == 8'h1E) ? 0 : 2;
                endcase
            end
            if (!hw_rst_n || ovf) begin
                m_en = 0; m_ps = 0; m_cnt = 0;
            end else begin
                if (cw && wrt && wr_data[5]) m_cnt = 0;
                else if ((m_en != 0) && rise) m_cnt = (m_cnt + 1) % (1 << CW);
                if (cw && wrt) begin
                    m_en = int'(wr_data[7]);
                    m_ps = int'(wr_data[2:0]);
                end
            end
        end
    end

    // compare 3 ns after each rising edge
    always @(posedge clk) begin
        logic [7:0] exp_rd;
        logic       exp_rst;
        #3;
        case (rd_addr)
            2'd0: exp_rd = {m_en[0], 4'b0000, m_ps[2:0]};
            2'd1: exp_rd = m_key[7:0];
            2'd2: exp_rd = {m_flag[0], 7'b0000000};
            default: exp_rd = 8'h00;
        endcase
        exp_rst = (m_pulse != 0);
        n_vec++;
        if (rd_data !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rd_data addr %0d: actual %h expected %h", cur_req, rd_addr, rd_data, exp_rd);
        end
        n_vec++;
        if (wdt_rst_o !== exp_rst) begin
            n_bad++;
            $display("FAIL %s wdt_rst_o: actual %b expected %b", cur_req, wdt_rst_o, exp_rst);
        end
    end

    // read-address rotator and slow tick source
    initial forever begin
        @(negedge clk);
        rd_addr = rd_addr + 2'd1;
    end

    initial forever begin
        repeat (2) @(negedge clk);
        if (tick_on) slow_tick = ~slow_tick;
        else         slow_tick = 1'b0;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(8);

        cur_req = "R2";
        wr(2'd0, 8'h87);
        wr(2'd0, 8'h81);

        cur_req = "R5";
        wr(2'd1, 8'h1E);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h83);

        cur_req = "R3";
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h80);

        cur_req = "R6 R9 R10";
        tick_on = 1'b1;
        idle(60);

        cur_req = "R8";
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h81);
        for (int i = 0; i < 6; i++) begin
            idle(14);
            wr(2'd0, 8'hA1);
        end
        idle(80);

        cur_req = "R4";
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'hE1);
        wr(2'd1, 8'h33);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'hE1);
        wr(2'd1, 8'h1E);
        wr(2'd0, 8'h87);

        cur_req = "R12";
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h80);
        idle(14);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        idle(30);

        cur_req = "R11";
        wr(2'd2, 8'h00);
        wr(2'd2, 8'hFF);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        idle(6);

        cur_req = "R7";
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h87);
        idle(2200);
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h82);
        idle(140);

        cur_req = "R9 R12";
        wr(2'd1, 8'h1E);
        wr(2'd1, 8'hE1);
        wr(2'd0, 8'h80);
        @(posedge wdt_rst_o);
        @(negedge clk);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        idle(10);

        cur_req = "R1 R11";
        tick_on = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(8);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule